// File: doc/BRIEF.md
# Per-Connection Cell Statistics Counters

This block holds six saturating 31-bit cell counters for each connection of a cell-switching line interface, kept in an internal RAM with one row per connection. The cell path reports each cell as a single-cycle count event. The event carries the connection index, whether the cell travels ingress or egress, its CLP bit and two policing verdict bits (nonconforming to bucket A, nonconforming to bucket B). The block turns each event into an increment mask over the six counters of that row and applies it with a two-stage read-modify-write. A result forwarding path covers the case where a row is read while its previous update is still being written.

A processor port reads or overwrites any single counter. A request is granted in the cycle it is presented, unless an enabled cell event for a different connection arrives in the same cycle. In that case the event wins and the request waits. A request and an event for the same connection merge into one update: the write is applied first and the event's increment lands on the written value. Read data returns in the cycle after the grant.

The control is a two-state machine. After reset it starts in `ST_CLEAR`, which zeroes one row per cycle. When the last row is written it takes the transition `CLEAR_DONE` into `ST_RUN`. It stays in `ST_RUN` until the next reset; the `RESET` transition leads from either state back to `ST_CLEAR`.

Top module: `stat_counters`

## Requirements
- R1: After reset every counter reads 0. During the clearing sweep of 2^CONN_W cycles, `cpu_gnt` stays low and count events are not counted.
- R2: Counter select encoding within a connection: 0 to 3 are the ingress counters, 4 is egress CLP0 and 5 is egress CLP1. A read granted at one clock edge gives `cpu_rvalid` high, with the counter value on `cpu_rdata`, during the following cycle only.
- R3: A granted write stores `cpu_wdata` into the selected counter. With select 6 or 7, a write changes no counter and a read returns 0.
- R4: With `ing_mode`=0, an ingress event increments counter 0 when CLP is 0 and counter 1 when CLP is 1. It also increments counter 2 when nonconforming to bucket A, and counter 3 when nonconforming to bucket B.
- R5: With `ing_mode`=1, an ingress event increments exactly one counter: 0 for conforming CLP0, 1 for conforming CLP1, 2 for nonconforming CLP0, 3 for nonconforming CLP1. A cell is nonconforming when either verdict bit is set.
- R6: An egress event increments counter 4 when CLP is 0 and counter 5 when CLP is 1; its verdict bits are ignored.
- R7: While `stat_en` is 0, count events change no counter.
- R8: A counter at 2^31-1 stays there when incremented.
- R9: A processor write and an event for the same connection in the same cycle are both granted. The written counter ends at the written value plus that event's increment for it.
- R10: Events on consecutive cycles to the same connection are all counted.
- R11: While running, `cpu_gnt` is high exactly when `cpu_req` is high and there is no enabled event for a different connection in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset; starts the clearing sweep |
| stat_en | input | 1 | Global counting enable |
| ing_mode | input | 1 | Ingress counting mode (0 or 1) |
| evt_valid | input | 1 | Count event present this cycle |
| evt_conn | input | CONN_W | Connection index of the event |
| evt_egress | input | 1 | 1 = egress cell, 0 = ingress cell |
| evt_clp | input | 1 | CLP bit of the cell |
| evt_nc_a | input | 1 | Cell nonconforming to bucket A |
| evt_nc_b | input | 1 | Cell nonconforming to bucket B |
| cpu_req | input | 1 | Processor access request, held until granted |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_conn | input | CONN_W | Connection index of the access |
| cpu_sel | input | 3 | Counter select within the connection |
| cpu_wdata | input | CNT_W | Write value |
| cpu_gnt | output | 1 | Request accepted at this clock edge |
| cpu_rvalid | output | 1 | Read data valid |
| cpu_rdata | output | CNT_W | Read data |

## Verification
The assertions assume that `cpu_req` and its fields are held stable until the grant. They also assume each event input is a single-cycle pulse carrying known values, and that `ing_mode` is meaningful only together with `evt_valid`. The bench drives every input on the falling edge. It holds a request until it sees `cpu_gnt` and never changes its fields in between. It lowers `evt_valid` as soon as the last event of a burst has been presented, and it changes `ing_mode` only alongside an event.

// File: rtl/stat_pkg.sv
package stat_pkg;

    localparam int unsigned STAT_NCNT = 6;
    localparam int unsigned SEL_W     = 3;

    typedef enum logic {
        ST_CLEAR = 1'b0,
        ST_RUN   = 1'b1
    } stat_state_t;

endpackage

// File: rtl/stat_evt_decode.sv
module stat_evt_decode
    import stat_pkg::*;
(
    input  logic                 egress,
    input  logic                 clp,
    input  logic                 nc_a,
    input  logic                 nc_b,
    input  logic                 mode,
    output logic [STAT_NCNT-1:0] mask
);

    logic nonconf;

    assign nonconf = nc_a | nc_b;

    always_comb begin
        mask = '0;
        if (egress) begin
            if (clp) mask[5] = 1'b1;
            else     mask[4] = 1'b1;
        end else if (!mode) begin
            if (clp) mask[1] = 1'b1;
            else     mask[0] = 1'b1;
            mask[2] = nc_a;
            mask[3] = nc_b;
        end else begin
            unique case ({nonconf, clp})
                2'b00: mask[0] = 1'b1;
                2'b01: mask[1] = 1'b1;
                2'b10: mask[2] = 1'b1;
                2'b11: mask[3] = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/stat_row_update.sv
module stat_row_update
    import stat_pkg::*;
#(
    parameter int CNT_W = 31
) (
    input  logic [STAT_NCNT-1:0][CNT_W-1:0] base_row,
    input  logic                            wr_en,
    input  logic [SEL_W-1:0]                wr_sel,
    input  logic [CNT_W-1:0]                wr_data,
    input  logic [STAT_NCNT-1:0]            inc_mask,
    output logic [STAT_NCNT-1:0][CNT_W-1:0] new_row
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    for (genvar i = 0; i < STAT_NCNT; i++) begin : g_field
        logic             hit;
        logic [CNT_W-1:0] pre;

        assign hit = wr_en && (wr_sel == SEL_W'(i));
        assign pre = hit ? wr_data : base_row[i];

        always_comb begin
            if (inc_mask[i] && (pre != CNT_MAX)) new_row[i] = pre + 1'b1;
            else                                 new_row[i] = pre;
        end
    end

endmodule

// File: rtl/stat_row_ram.sv
module stat_row_ram #(
    parameter  int DEPTH = 16,
    parameter  int W     = 186,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/stat_counters.sv
module stat_counters
    import stat_pkg::*;
#(
    parameter int CONN_W = 4,
    parameter int CNT_W  = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stat_en,
    input  logic              ing_mode,
    input  logic              evt_valid,
    input  logic [CONN_W-1:0] evt_conn,
    input  logic              evt_egress,
    input  logic              evt_clp,
    input  logic              evt_nc_a,
    input  logic              evt_nc_b,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [CONN_W-1:0] cpu_conn,
    input  logic [SEL_W-1:0]  cpu_sel,
    input  logic [CNT_W-1:0]  cpu_wdata,
    output logic              cpu_gnt,
    output logic              cpu_rvalid,
    output logic [CNT_W-1:0]  cpu_rdata
);

    localparam int                NCONN    = 2 ** CONN_W;
    localparam int                ROW_W    = STAT_NCNT * CNT_W;
    localparam logic [CONN_W-1:0] LAST_ROW = CONN_W'(NCONN - 1);

    typedef logic [STAT_NCNT-1:0][CNT_W-1:0] row_t;

    // ---------------- control state machine ----------------
    stat_state_t       state, state_nx;
    logic              running, clearing;
    logic [CONN_W-1:0] clr_idx;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) state <= ST_CLEAR;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_CLEAR: if (clr_idx == LAST_ROW) state_nx = ST_RUN;
            ST_RUN:   state_nx = ST_RUN;
        endcase
    end

    always_comb begin
        running  = 1'b0;
        clearing = 1'b0;
        unique case (state)
            ST_CLEAR: clearing = 1'b1;
            ST_RUN:   running  = 1'b1;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst)           clr_idx <= '0;
        else if (clearing) clr_idx <= clr_idx + 1'b1;
    end

    // ---------------- arbitration ----------------
    logic                 evt_take;
    logic                 op_vld;
    logic [CONN_W-1:0]    op_row;
    logic [STAT_NCNT-1:0] evt_mask;

    assign evt_take = running && evt_valid && stat_en;
    assign cpu_gnt  = running && cpu_req && (!evt_take || (evt_conn == cpu_conn));
    assign op_vld   = evt_take || cpu_gnt;
    assign op_row   = evt_take ? evt_conn : cpu_conn;

    stat_evt_decode u_dec (
        .egress (evt_egress),
        .clp    (evt_clp),
        .nc_a   (evt_nc_a),
        .nc_b   (evt_nc_b),
        .mode   (ing_mode),
        .mask   (evt_mask)
    );

    // ---------------- update stage registers ----------------
    logic                 s1_vld;
    logic [CONN_W-1:0]    s1_row;
    logic [STAT_NCNT-1:0] s1_mask;
    logic                 s1_cwr, s1_crd;
    logic [SEL_W-1:0]     s1_sel;
    logic [CNT_W-1:0]     s1_wdata;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            s1_vld   <= 1'b0;
            s1_row   <= '0;
            s1_mask  <= '0;
            s1_cwr   <= 1'b0;
            s1_crd   <= 1'b0;
            s1_sel   <= '0;
            s1_wdata <= '0;
        end else begin
            s1_vld   <= op_vld;
            s1_row   <= op_row;
            s1_mask  <= evt_take ? evt_mask : '0;
            s1_cwr   <= cpu_gnt && cpu_we;
            s1_crd   <= cpu_gnt && !cpu_we;
            s1_sel   <= cpu_sel;
            s1_wdata <= cpu_wdata;
        end
    end

    // ---------------- storage and forwarding ----------------
    logic [ROW_W-1:0]  ram_rdata, ram_wdata;
    logic              ram_we;
    logic [CONN_W-1:0] ram_waddr;
    row_t              base_row, new_row, fwd_data;
    logic              fwd_vld;
    logic [CONN_W-1:0] fwd_row;

    assign ram_we    = clearing || s1_vld;
    assign ram_waddr = clearing ? clr_idx : s1_row;
    assign ram_wdata = clearing ? '0 : ROW_W'(new_row);

    stat_row_ram #(.DEPTH(NCONN), .W(ROW_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (op_row),
        .rdata (ram_rdata)
    );

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            fwd_vld  <= 1'b0;
            fwd_row  <= '0;
            fwd_data <= '0;
        end else begin
            fwd_vld  <= running && s1_vld;
            fwd_row  <= s1_row;
            fwd_data <= new_row;
        end
    end

    assign base_row = (fwd_vld && (fwd_row == s1_row)) ? fwd_data : row_t'(ram_rdata);

    stat_row_update #(.CNT_W(CNT_W)) u_upd (
        .base_row (base_row),
        .wr_en    (s1_cwr),
        .wr_sel   (s1_sel),
        .wr_data  (s1_wdata),
        .inc_mask (s1_mask),
        .new_row  (new_row)
    );

    // ---------------- read return ----------------
    logic [CNT_W-1:0] rd_field;

    always_comb begin
        rd_field = '0;
        for (int i = 0; i < STAT_NCNT; i++) begin
            if (s1_sel == SEL_W'(i)) rd_field = base_row[i];
        end
    end

    assign cpu_rvalid = s1_crd;
    assign cpu_rdata  = s1_crd ? rd_field : '0;

endmodule

// File: rtl/stat_counters_chk.sv
module stat_counters_chk
    import stat_pkg::*;
#(
    parameter int CONN_W = 4,
    parameter int CNT_W  = 31
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            running,
    input logic                            stat_en,
    input logic                            evt_valid,
    input logic [CONN_W-1:0]               evt_conn,
    input logic                            cpu_req,
    input logic                            cpu_we,
    input logic [CONN_W-1:0]               cpu_conn,
    input logic                            cpu_gnt,
    input logic                            cpu_rvalid,
    input logic                            s1_vld,
    input logic                            s1_cwr,
    input logic [SEL_W-1:0]                s1_sel,
    input logic [STAT_NCNT-1:0][CNT_W-1:0] base_row,
    input logic [STAT_NCNT-1:0][CNT_W-1:0] new_row
);

    a_r1_no_grant_while_clearing: assert property (@(posedge clk) disable iff (rst)
        !running |-> !cpu_gnt);

    a_r11_grant_needs_request: assert property (@(posedge clk) disable iff (rst)
        cpu_gnt |-> cpu_req);

    a_r11_event_blocks_other_conn: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && stat_en && evt_conn != cpu_conn) |-> !cpu_gnt);

    a_r11_grant_when_free: assert property (@(posedge clk) disable iff (rst)
        (running && cpu_req && !(evt_valid && stat_en)) |-> cpu_gnt);

    a_r2_read_returns_next: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_gnt && !cpu_we) |=> cpu_rvalid);

    a_r2_rvalid_only_after_read: assert property (@(posedge clk) disable iff (rst)
        cpu_rvalid |-> $past(cpu_req && cpu_gnt && !cpu_we));

    for (genvar i = 0; i < STAT_NCNT; i++) begin : g_fld
        a_r8_saturate_hold: assert property (@(posedge clk) disable iff (rst)
            (s1_vld && !(s1_cwr && s1_sel == SEL_W'(i)) && (&base_row[i]))
                |-> (&new_row[i]));

        a_r10_step_at_most_one: assert property (@(posedge clk) disable iff (rst)
            (s1_vld && !(s1_cwr && s1_sel == SEL_W'(i)))
                |-> (new_row[i] == base_row[i] || new_row[i] == base_row[i] + 1'b1));
    end

endmodule

bind stat_counters stat_counters_chk #(.CONN_W(CONN_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .running    (running),
    .stat_en    (stat_en),
    .evt_valid  (evt_valid),
    .evt_conn   (evt_conn),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_conn   (cpu_conn),
    .cpu_gnt    (cpu_gnt),
    .cpu_rvalid (cpu_rvalid),
    .s1_vld     (s1_vld),
    .s1_cwr     (s1_cwr),
    .s1_sel     (s1_sel),
    .base_row   (base_row),
    .new_row    (new_row)
);

// File: tb/tb_stat_counters.sv
module tb_stat_counters;

    localparam int CONN_W = 4;
    localparam int CNT_W  = 31;
    localparam int NCONN  = 2 ** CONN_W;

    logic              clk = 1'b0;
    logic              rst;
    logic              stat_en, ing_mode;
    logic              evt_valid, evt_egress, evt_clp, evt_nc_a, evt_nc_b;
    logic [CONN_W-1:0] evt_conn;
    logic              cpu_req, cpu_we;
    logic [CONN_W-1:0] cpu_conn;
    logic [2:0]        cpu_sel;
    logic [CNT_W-1:0]  cpu_wdata;
    logic              cpu_gnt, cpu_rvalid;
    logic [CNT_W-1:0]  cpu_rdata;

    int checks = 0;
    int errors = 0;
    int mdl [NCONN][6];

    always #5 clk = ~clk;

    stat_counters #(.CONN_W(CONN_W), .CNT_W(CNT_W)) dut (.*);

    // {mode, egress, clp, nc_a, nc_b, conn[3:0], expected increment mask[5:0]}
    localparam logic [14:0] VEC [12] = '{
        {5'b0_0_0_0_0, 4'd1, 6'b000001},
        {5'b0_0_0_0_0, 4'd1, 6'b000001},
        {5'b0_0_1_1_0, 4'd1, 6'b000110},
        {5'b0_0_0_1_1, 4'd1, 6'b001101},
        {5'b1_0_0_0_0, 4'd4, 6'b000001},
        {5'b1_0_1_0_0, 4'd4, 6'b000010},
        {5'b1_0_0_0_1, 4'd4, 6'b000100},
        {5'b1_0_1_1_0, 4'd4, 6'b001000},
        {5'b0_1_0_1_1, 4'd6, 6'b010000},
        {5'b0_1_1_0_0, 4'd6, 6'b100000},
        {5'b1_1_1_0_0, 4'd6, 6'b100000},
        {5'b0_0_1_0_0, 4'd7, 6'b000010}
    };

    task automatic chk(input string tag, input logic [CNT_W-1:0] got, input logic [CNT_W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic cpu_op(input logic we, input int conn, input int sel,
                          input logic [CNT_W-1:0] wd, output logic [CNT_W-1:0] rd);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_conn = CONN_W'(conn);
        cpu_sel = 3'(sel); cpu_wdata = wd;
        #1;
        while (!cpu_gnt) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        rd = cpu_rdata;
        if (!we) chk("R2 rvalid", {30'd0, cpu_rvalid}, 31'd1);
        cpu_req = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input int conn, input int sel, input logic [CNT_W-1:0] exp);
        logic [CNT_W-1:0] v;
        cpu_op(1'b0, conn, sel, '0, v);
        chk(tag, v, exp);
    endtask

    task automatic wr(input int conn, input int sel, input logic [CNT_W-1:0] wd);
        logic [CNT_W-1:0] v;
        cpu_op(1'b1, conn, sel, wd, v);
    endtask

    task automatic set_evt(input logic v, input logic mode, input logic egr, input logic clp,
                           input logic na, input logic nb, input int conn);
        evt_valid = v; ing_mode = mode; evt_egress = egr; evt_clp = clp;
        evt_nc_a = na; evt_nc_b = nb; evt_conn = CONN_W'(conn);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        stat_en = 1'b1; cpu_req = 1'b0; cpu_we = 1'b0; cpu_conn = '0; cpu_sel = '0; cpu_wdata = '0;
        set_evt(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0);
        for (int c = 0; c < NCONN; c++) for (int s = 0; s < 6; s++) mdl[c][s] = 0;
        do_reset();

        // R1: no grant and no counting during the clearing sweep
        cpu_req = 1'b1; cpu_conn = 4'd3; cpu_sel = 3'd0;
        set_evt(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3);
        #1;
        chk("R1 gnt during clear", {30'd0, cpu_gnt}, 31'd0);
        @(negedge clk); #1;
        chk("R1 gnt during clear", {30'd0, cpu_gnt}, 31'd0);
        cpu_req = 1'b0;
        repeat (3) @(negedge clk);
        evt_valid = 1'b0;
        repeat (NCONN + 2) @(negedge clk);
        rd_chk("R1 cleared conn3", 3, 0, 0);
        rd_chk("R1 cleared conn15", 15, 5, 0);

        // R4 R5 R6 R10: vector table applied back to back
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            set_evt(1'b1, VEC[k][14], VEC[k][13], VEC[k][12], VEC[k][11], VEC[k][10], int'(VEC[k][9:6]));
            for (int s = 0; s < 6; s++) mdl[VEC[k][9:6]][s] += int'(VEC[k][s]);
        end
        @(negedge clk);
        evt_valid = 1'b0;
        for (int s = 0; s < 6; s++) begin
            rd_chk("R4 R10 mode0 conn1", 1, s, CNT_W'(mdl[1][s]));
            rd_chk("R5 mode1 conn4", 4, s, CNT_W'(mdl[4][s]));
            rd_chk("R6 egress conn6", 6, s, CNT_W'(mdl[6][s]));
            rd_chk("R4 conn7", 7, s, CNT_W'(mdl[7][s]));
        end

        // R3: write and read back, invalid selects
        wr(8, 3, 31'h1234);
        rd_chk("R3 write readback", 8, 3, 31'h1234);
        wr(3, 6, 31'd55);
        rd_chk("R3 sel6 reads zero", 3, 6, 0);
        rd_chk("R3 sel6 write no effect c0", 3, 0, 0);
        rd_chk("R3 sel6 write no effect c5", 3, 5, 0);

        // R7: disabled counting
        @(negedge clk);
        stat_en = 1'b0;
        set_evt(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 9);
        repeat (2) @(negedge clk);
        evt_valid = 1'b0; stat_en = 1'b1;
        rd_chk("R7 disabled clp1", 9, 1, 0);
        rd_chk("R7 disabled nca", 9, 2, 0);

        // R8: saturation
        wr(5, 4, 31'h7FFFFFFE);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            set_evt(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5);
        end
        @(negedge clk);
        evt_valid = 1'b0;
        rd_chk("R8 saturate", 5, 4, 31'h7FFFFFFF);

        // R9: merged write and event on the same connection
        @(negedge clk);
        set_evt(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_conn = 4'd2; cpu_sel = 3'd0; cpu_wdata = 31'd100;
        #1;
        chk("R9 merged grant", {30'd0, cpu_gnt}, 31'd1);
        @(negedge clk);
        cpu_sel = 3'd5; cpu_wdata = 31'd40;
        #1;
        chk("R9 merged grant 2", {30'd0, cpu_gnt}, 31'd1);
        @(negedge clk);
        cpu_req = 1'b0; evt_valid = 1'b0;
        rd_chk("R9 write then inc", 2, 0, 31'd102);
        rd_chk("R9 other field written", 2, 5, 31'd40);

        // R11: arbitration against events
        @(negedge clk);
        set_evt(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 11);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_conn = 4'd12; cpu_sel = 3'd4;
        #1;
        chk("R11 blocked by other conn", {30'd0, cpu_gnt}, 31'd0);
        @(negedge clk);
        evt_conn = 4'd12;
        #1;
        chk("R11 granted same conn", {30'd0, cpu_gnt}, 31'd1);
        @(negedge clk);
        evt_valid = 1'b0; cpu_req = 1'b0;
        chk("R2 merged read rvalid", {30'd0, cpu_rvalid}, 31'd1);
        chk("R2 merged read value", cpu_rdata, 0);
        rd_chk("R11 blocking event counted", 11, 4, 31'd1);
        rd_chk("R11 merged event counted", 12, 4, 31'd1);
        @(negedge clk);
        stat_en = 1'b0;
        set_evt(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 13);
        cpu_req = 1'b1; cpu_conn = 4'd14;
        #1;
        chk("R11 disabled event no block", {30'd0, cpu_gnt}, 31'd1);
        @(negedge clk);
        cpu_req = 1'b0; evt_valid = 1'b0; stat_en = 1'b1;

        // R1: reset mid-run clears stored counts
        wr(10, 1, 31'd77);
        rd_chk("R3 pre-reset value", 10, 1, 31'd77);
        do_reset();
        repeat (NCONN + 2) @(negedge clk);
        rd_chk("R1 cleared after reset", 10, 1, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule